// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block is an eight-channel output-compare stage for a free-running timer. A counter of parameterized width counts up on every clock. Each channel holds its own compare value. When the counter reaches that value, the channel's two-bit action code is applied to the channel's output latch. The code can leave the latch alone, invert it, force it low or force it high.

The action code also decides who owns each port pin. Any non-zero code hands the pin to the timer, which drives it from the channel latch and forces it to output. A zero code leaves the pin to the general-purpose data and direction inputs. A separate suppress mask can block the compare action on chosen channels. The mask does not change who owns the pin.

Software reaches the block over a simple single-cycle register bus. The bus holds two action-code registers, the suppress mask and one compare register per channel.

Top module: `oc_pin_unit`

## Requirements
- R1: `tmr_count` resets to 0, rises by exactly one on every clock and wraps modulo 2^CNT_W.
- R2: The action codes live in two registers. Address 0 holds channels 7..4 and address 1 holds channels 3..0. Channel n uses bits [2k+1:2k] with k = n mod 4: the mode bit is the upper bit of the pair and the level bit the lower. Both registers reset to 0, can be written at any time, and read back what was written in bits [7:0].
- R3: Code 01 (toggle) inverts the channel latch on each compare match. The new latch value is visible once `tmr_count` reads C+2, where C is the compare value.
- R4: Code 10 forces the latch to 0 on a match, and code 11 forces it to 1, with the same C+2 timing as R3.
- R5: With code 00 the pin follows the general-purpose inputs (`pin_oe` = `gp_dir` bit, `pin_out` = `gp_dout` bit), and a match leaves the latch unchanged.
- R6: With any non-zero code, `pin_oe` is 1 whatever `gp_dir` says, and `pin_out` shows the channel latch.
- R7: The suppress mask sits at address 2, with bit n for channel n, and resets to 0. A channel whose mask bit is 1 keeps its latch on a match, but its pin stays under timer ownership.
- R8: When a code write and a match fall in the same cycle, the match uses the code that was in force before the write.
- R9: Every channel latch resets to 0.
- R10: A channel left on toggle produces a square wave whose half-period is 2^CNT_W clocks.
- R11: The compare register for channel n sits at address 8+n. It resets to 0 and reads back its CNT_W bits, zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| gp_dout | input | NCH | General-purpose pin data |
| gp_dir | input | NCH | General-purpose pin direction (1 = output) |
| pin_out | output | NCH | Value driven to each pin |
| pin_oe | output | NCH | Output enable for each pin |
| tmr_count | output | CNT_W | Free-running counter value |

## Verification
The hardest case to reach from the ports is a code write that lands in exactly the cycle where the counter equals a channel's compare value. Observing it needs the latch in a known state first, so that the old code and the new code would leave different values. The stimulus clears the channel's latch through an earlier match. It then polls `tmr_count` at falling edges until it reads the compare value, and asserts the write strobe at that very edge. The latch is read once the counter reaches C+2. The bench uses an 8-bit counter so that the toggle half-period test covers full wraps quickly.

// File: rtl/oc_pkg.sv
package oc_pkg;
    typedef enum logic [1:0] {
        ACT_OFF = 2'b00,
        ACT_TOG = 2'b01,
        ACT_CLR = 2'b10,
        ACT_SET = 2'b11
    } oc_act_e;

    localparam int ADDR_CTL_HI   = 0;
    localparam int ADDR_CTL_LO   = 1;
    localparam int ADDR_MASK     = 2;
    localparam int ADDR_CMP_BASE = 8;
endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> s_q.cnt == CNT_W'($past(s_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/oc_regs.sv
module oc_regs
    import oc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [2*NCH-1:0]         ctl,
    output logic [NCH-1:0]           mask,
    output logic [NCH-1:0][CNT_W-1:0] cmp
);
    localparam int CTL_W = 2 * NCH;
    localparam int HALF  = CTL_W / 2;

    typedef struct packed {
        logic [CTL_W-1:0]           ctl;
        logic [NCH-1:0]             mask;
        logic [NCH-1:0][CNT_W-1:0]  cmp;
    } reg_st_t;

    reg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            if (addr == ADDR_W'(ADDR_CTL_HI)) s_d.ctl[CTL_W-1:HALF] = wdata[HALF-1:0];
            if (addr == ADDR_W'(ADDR_CTL_LO)) s_d.ctl[HALF-1:0]     = wdata[HALF-1:0];
            if (addr == ADDR_W'(ADDR_MASK))   s_d.mask              = wdata[NCH-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (addr == ADDR_W'(ADDR_CMP_BASE + n)) s_d.cmp[n] = wdata[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTL_HI)) rdata[HALF-1:0] = s_q.ctl[CTL_W-1:HALF];
        if (addr == ADDR_W'(ADDR_CTL_LO)) rdata[HALF-1:0] = s_q.ctl[HALF-1:0];
        if (addr == ADDR_W'(ADDR_MASK))   rdata[NCH-1:0]  = s_q.mask;
        for (int n = 0; n < NCH; n++) begin
            if (addr == ADDR_W'(ADDR_CMP_BASE + n)) rdata = DATA_W'(s_q.cmp[n]);
        end
    end

    assign ctl  = s_q.ctl;
    assign mask = s_q.mask;
    assign cmp  = s_q.cmp;

    // R2
    ctl_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we && addr == ADDR_W'(ADDR_CTL_HI) |=> ctl[CTL_W-1:HALF] == $past(wdata[HALF-1:0]));

    // R7
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we && addr == ADDR_W'(ADDR_MASK) |=> mask == $past(wdata[NCH-1:0]));
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [1:0]       code,
    input  logic             mask_bit,
    input  logic             gp_dout,
    input  logic             gp_dir,
    output logic             pin_out,
    output logic             pin_oe
);
    typedef struct packed {
        logic    match;
        oc_act_e act;
        logic    lat;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic   own;

    always_comb begin
        s_d       = s_q;
        s_d.match = (cnt == cmp) && !mask_bit;
        s_d.act   = oc_act_e'(code);
        if (s_q.match) begin
            unique case (s_q.act)
                ACT_TOG: s_d.lat = !s_q.lat;
                ACT_CLR: s_d.lat = 1'b0;
                ACT_SET: s_d.lat = 1'b1;
                default: s_d.lat = s_q.lat;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{match: 1'b0, act: ACT_OFF, lat: 1'b0};
        else        s_q <= s_d;
    end

    assign own     = (code != 2'b00);
    assign pin_out = own ? s_q.lat : gp_dout;
    assign pin_oe  = own ? 1'b1    : gp_dir;

    // R5
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.match |=> $stable(s_q.lat));

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match && s_q.act == ACT_TOG |=> s_q.lat != $past(s_q.lat));

    // R4
    set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match && s_q.act == ACT_SET |=> s_q.lat);

    // R4
    clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match && s_q.act == ACT_CLR |=> !s_q.lat);

    // R7
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bit |=> !s_q.match);
endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
    import oc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    gp_dout,
    input  logic [NCH-1:0]    gp_dir,
    output logic [NCH-1:0]    pin_out,
    output logic [NCH-1:0]    pin_oe,
    output logic [CNT_W-1:0]  tmr_count
);
    logic [CNT_W-1:0]           cnt;
    logic [2*NCH-1:0]           ctl;
    logic [NCH-1:0]             mask;
    logic [NCH-1:0][CNT_W-1:0]  cmp;

    oc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt)
    );

    oc_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bus_we),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .rdata(bus_rdata),
        .ctl  (ctl),
        .mask (mask),
        .cmp  (cmp)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        oc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .cmp     (cmp[n]),
            .code    (ctl[2*n+1:2*n]),
            .mask_bit(mask[n]),
            .gp_dout (gp_dout[n]),
            .gp_dir  (gp_dir[n]),
            .pin_out (pin_out[n]),
            .pin_oe  (pin_oe[n])
        );
    end

    assign tmr_count = cnt;
endmodule

// File: tb/sim_oc_pin_unit.sv
module sim_oc_pin_unit;
    localparam int NCH = 8, CNT_W = 8, ADDR_W = 4, DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCH-1:0] gp_dout = '0, gp_dir = '0;
    logic [NCH-1:0] pin_out, pin_oe;
    logic [CNT_W-1:0] tmr_count;

    always #5 clk = ~clk;

    oc_pin_unit #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gp_dout(gp_dout),
        .gp_dir(gp_dir), .pin_out(pin_out), .pin_oe(pin_oe), .tmr_count(tmr_count)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int cyc = 0;
    logic [15:0] shadow = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // {channel[2:0], code[1:0], expected latch}
    localparam logic [5:0] VEC [8] = '{
        {3'd0, 2'b11, 1'b1}, {3'd0, 2'b01, 1'b0}, {3'd0, 2'b01, 1'b1},
        {3'd0, 2'b10, 1'b0}, {3'd5, 2'b11, 1'b1}, {3'd5, 2'b10, 1'b0},
        {3'd7, 2'b01, 1'b1}, {3'd3, 2'b11, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
    endtask

    task automatic set_code(input int ch, input logic [1:0] code);
        shadow[2*ch +: 2] = code;
        if (ch >= 4) wr(0, DATA_W'(shadow[15:8]));
        else         wr(1, DATA_W'(shadow[7:0]));
    endtask

    task automatic arm(input int ch, output logic [CNT_W-1:0] c);
        c = CNT_W'(tmr_count + 8);
        wr(8 + ch, DATA_W'(c));
    endtask

    task automatic wait_cnt(input logic [CNT_W-1:0] v);
        while (tmr_count != v) @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] own_bits();
        logic [NCH-1:0] o;
        for (int n = 0; n < NCH; n++) o[n] = |shadow[2*n +: 2];
        return o;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic [CNT_W-1:0] c, a;
        int t0;
        logic prev;

        gp_dir = 8'h00; gp_dout = 8'hA5;
        repeat (3) @(negedge clk);
        chk(tmr_count == 0, "R1 count in reset", tmr_count, 0);
        chk(pin_oe == gp_dir && pin_out == gp_dout, "R5 pins in reset", {pin_oe, pin_out}, {gp_dir, gp_dout});
        rst_n = 1'b1;
        @(negedge clk);
        a = tmr_count;
        @(negedge clk);
        chk(tmr_count == CNT_W'(a + 1), "R1 count step", tmr_count, CNT_W'(a + 1));

        rd(0, d); chk(d == 0, "R2 ctl hi reset", d, 0);
        rd(1, d); chk(d == 0, "R2 ctl lo reset", d, 0);
        rd(2, d); chk(d == 0, "R7 mask reset", d, 0);
        rd(8 + 4, d); chk(d == 0, "R11 cmp reset", d, 0);

        // R9: latch is 0 out of reset, shown as soon as the timer owns the pin
        set_code(2, 2'b10);
        chk(pin_out[2] == 1'b0 && pin_oe[2], "R9 latch reset", {pin_oe[2], pin_out[2]}, 2'b10);
        set_code(2, 2'b00);

        // R11 readback
        wr(8 + 5, 16'h1234);
        rd(8 + 5, d); chk(d == 16'h0034, "R11 cmp readback", d, 16'h0034);

        // R2 layout: channel 5 code 11 sits at bits [3:2] of register 0
        set_code(5, 2'b11);
        rd(0, d); chk(d == 16'h000C, "R2 ch5 field", d, 16'h000C);
        set_code(5, 2'b00);
        wr(1, 16'h00B4);
        rd(1, d); chk(d == 16'h00B4, "R2 ctl lo write", d, 16'h00B4);
        wr(1, 16'h0000);

        // R3 R4 R6 vector table
        for (int i = 0; i < 8; i++) begin
            int ch;
            logic [1:0] code;
            logic ex;
            ch = int'(VEC[i][5:3]); code = VEC[i][2:1]; ex = VEC[i][0];
            arm(ch, c);
            set_code(ch, code);
            wait_cnt(CNT_W'(c + 2));
            chk(pin_out[ch] == ex, (code == 2'b01) ? "R3 toggle result" : "R4 force result", pin_out[ch], ex);
            chk(pin_oe == (gp_dir | own_bits()), "R6 ownership", pin_oe, gp_dir | own_bits());
            set_code(ch, 2'b00);
        end

        // R5: code 00 leaves pins to gp inputs and holds the latch (ch3 latch is 1)
        gp_dir = 8'h5A; gp_dout = 8'h30;
        arm(3, c);
        wait_cnt(CNT_W'(c + 3));
        chk(pin_oe == gp_dir && pin_out == gp_dout, "R5 gp follow", {pin_oe, pin_out}, {gp_dir, gp_dout});
        wr(8 + 3, DATA_W'(CNT_W'(tmr_count + 100)));
        set_code(3, 2'b10);
        chk(pin_out[3] == 1'b1, "R5 latch held", pin_out[3], 1'b1);
        set_code(3, 2'b00);
        gp_dir = 8'h00;

        // R7: mask suppresses the action, pin stays timer-owned
        wr(2, 16'h0040);
        rd(2, d); chk(d == 16'h0040, "R7 mask readback", d, 16'h0040);
        set_code(6, 2'b01);
        arm(6, c);
        wait_cnt(CNT_W'(c + 3));
        chk(pin_out[6] == 1'b0 && pin_oe[6], "R7 masked hold", {pin_oe[6], pin_out[6]}, 2'b10);
        wr(2, 16'h0000);
        arm(6, c);
        wait_cnt(CNT_W'(c + 2));
        chk(pin_out[6] == 1'b1, "R7 unmasked toggle", pin_out[6], 1'b1);
        set_code(6, 2'b00);

        // R8: write on the match cycle uses the old code
        set_code(1, 2'b10);
        arm(1, c);
        wait_cnt(CNT_W'(c + 2));
        chk(pin_out[1] == 1'b0, "R8 pre-clear", pin_out[1], 1'b0);
        arm(1, c);
        wait_cnt(c);
        shadow[3:2] = 2'b11;
        bus_we = 1'b1; bus_addr = ADDR_W'(1); bus_wdata = DATA_W'(shadow[7:0]);
        @(negedge clk);
        bus_we = 1'b0;
        wait_cnt(CNT_W'(c + 2));
        chk(pin_out[1] == 1'b0, "R8 old code used", pin_out[1], 1'b0);
        arm(1, c);
        wait_cnt(CNT_W'(c + 2));
        chk(pin_out[1] == 1'b1, "R8 new code later", pin_out[1], 1'b1);
        set_code(1, 2'b00);

        // R10: toggle half-period
        set_code(2, 2'b01);
        arm(2, c);
        wait_cnt(CNT_W'(c + 2));
        t0 = cyc; prev = pin_out[2];
        @(negedge clk);
        while (pin_out[2] == prev) @(negedge clk);
        chk(cyc - t0 == (1 << CNT_W), "R10 half period", cyc - t0, 1 << CNT_W);
        t0 = cyc; prev = pin_out[2];
        @(negedge clk);
        while (pin_out[2] == prev) @(negedge clk);
        chk(cyc - t0 == (1 << CNT_W), "R10 second half", cyc - t0, 1 << CNT_W);
        set_code(2, 2'b00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule